// File: doc/BRIEF.md
# Per-Pin Interrupt Sensitivity Unit

This block watches 32 already-synchronized input pins and records, per pin, a sticky event bit whenever the pin shows the activity its sensitivity mode selects. Each pin has a 2-bit mode. The modes select a rising edge, a falling edge, both edges, or a reserved code that never fires. A build-time set of pins treats the rising and falling codes as active-high and active-low levels instead of edges. The event bits are masked and ORed into a single registered interrupt line. Software clears each event bit by writing a one to it.

Software reaches the unit through a plain single-cycle register port. It writes the mode fields, the mask and a direction register, and it clears events through the same port. Reads return one cycle later with a valid strobe. Pins named at build time as input-only can never have their direction bit set. Register layout (byte offsets):
- 0x00: direction
- 0x0C: events
- 0x10: mask
- 0x14: modes for pins 0-15
- 0x18: modes for pins 16-31

Top module: `gpio_sense_unit`

## Requirements
- R1: After reset, the direction, event, mask and both mode registers read 0, and `irq` is 0.
- R2: Pin p takes its mode from the register at 0x14 when p < 16, or from the register at 0x18 when p >= 16. The mode occupies bits [(15 - p mod 16)*2 +: 2], and the written mode registers read back unchanged.
- R3: Mode 1 on an edge pin sets event bit (31 - p) on a 0-to-1 change of the pin, and not on a 1-to-0 change.
- R4: Mode 2 on an edge pin sets event bit (31 - p) on a 1-to-0 change, and not on a 0-to-1 change.
- R5: Mode 0 (the reset value) sets event bit (31 - p) on every change of the pin.
- R6: Mode 3 never sets an event, whatever the pin does.
- R7: On a level pin (default pins 8 and 9), mode 1 sets the event on every cycle the pin is high and mode 2 on every cycle it is low. While the level stays active, a cleared bit is set again on the cycle after the clear.
- R8: Writing the event register at 0x0C clears each bit written as 1 and leaves bits written as 0 alone. A clear wins over a new event in the same cycle.
- R9: `irq` is a register that goes high one cycle after any event bit is set with its mask bit (same bit position at 0x10) also set. An unmasked event alone never raises it.
- R10: Direction bits (register bit 31 - p) for input-only pins (default pins 28-31) ignore writes and read 0. The `pin_dir` port carries pin p at bit p.
- R11: A read returns `rdata` with `rd_valid` high exactly one cycle after `rd_en`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronized pin levels, pin p at bit p |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rdata | output | 32 | Read data |
| pin_dir | output | 32 | Direction per pin (1 = output), pin p at bit p |
| irq | output | 1 | Combined masked interrupt |

## Verification
Each mode is driven with both a rising and a falling transition on the same pin. This separates rising-only, falling-only, both-edge and reserved behaviour. It also shows that a pin in the upper half decodes its field from the second register at a reversed position. The level pins are held active across a clear, and the bench reads the register on the two following cycles to see the bit drop and then return. A pin transition is issued in the very cycle of a clear, which shows the clear taking priority. A masked and an unmasked event are raised separately, so that `irq` is shown to follow only the masked bits, with the expected one-cycle lag.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

  typedef enum logic [1:0] {
    SNS_BOTH = 2'd0,
    SNS_RISE = 2'd1,
    SNS_FALL = 2'd2,
    SNS_RSVD = 2'd3
  } sense_mode_e;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DIR    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_EVT    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MSK    = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_SNS_LO = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_SNS_HI = 5'h18;

endpackage

// File: rtl/gpio_sense_field_map.sv
// Pulls each pin's 2-bit mode out of the two mode registers.
module gpio_sense_field_map
  import gpio_sense_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] sns_lo_i,
  input  logic [NPINS-1:0] sns_hi_i,
  output sense_mode_e      mode_o [NPINS]
);
  localparam int HALF = NPINS / 2;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int BASE = (HALF - 1 - (p % HALF)) * 2;
    if (p < HALF) begin : g_lo
      assign mode_o[p] = sense_mode_e'(sns_lo_i[BASE +: 2]);
    end else begin : g_hi
      assign mode_o[p] = sense_mode_e'(sns_hi_i[BASE +: 2]);
    end
  end
endmodule

// File: rtl/gpio_pin_event.sv
// Per-pin detector: edge or level variant chosen at build time.
module gpio_pin_event
  import gpio_sense_pkg::*;
#(
  parameter bit LEVEL = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pin_i,
  input  sense_mode_e mode_i,
  output logic        set_o
);
  logic prev_q;

  // Loaded during reset too, so a pin already high is not an edge.
  always_ff @(posedge clk) prev_q <= pin_i;

  if (LEVEL) begin : g_level
    always_comb begin
      unique case (mode_i)
        SNS_BOTH: set_o = pin_i ^ prev_q;
        SNS_RISE: set_o = pin_i;
        SNS_FALL: set_o = ~pin_i;
        default:  set_o = 1'b0;
      endcase
    end
  end else begin : g_edge
    always_comb begin
      unique case (mode_i)
        SNS_BOTH: set_o = pin_i ^ prev_q;
        SNS_RISE: set_o = pin_i & ~prev_q;
        SNS_FALL: set_o = ~pin_i & prev_q;
        default:  set_o = 1'b0;
      endcase
    end
  end

  assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == SNS_RSVD) |-> !set_o);
endmodule

// File: rtl/gpio_event_bank.sv
// Sticky event register with write-one-to-clear and masked interrupt.
module gpio_event_bank #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] set_vec_i,
  input  logic [NPINS-1:0] clr_vec_i,
  input  logic [NPINS-1:0] msk_i,
  output logic [NPINS-1:0] evt_o,
  output logic             irq_o
);
  logic [NPINS-1:0] evt_q;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= (evt_q | set_vec_i) & ~clr_vec_i;
      irq_q <= |(evt_q & msk_i);
    end
  end

  assign evt_o = evt_q;
  assign irq_o = irq_q;

  assert_w1c_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|clr_vec_i) |=> ((evt_q & $past(clr_vec_i)) == '0));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    ##1 (irq_q == $past(|(evt_q & msk_i))));
endmodule

// File: rtl/gpio_sense_unit.sv
module gpio_sense_unit
  import gpio_sense_pkg::*;
#(
  parameter int               NPINS        = 32,
  parameter logic [NPINS-1:0] IN_ONLY_PINS = 32'hF000_0000,
  parameter logic [NPINS-1:0] LEVEL_PINS   = 32'h0000_0300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic              rd_valid,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  pin_dir,
  output logic              irq
);
  function automatic logic [NPINS-1:0] flip(input logic [NPINS-1:0] v);
    logic [NPINS-1:0] r;
    for (int i = 0; i < NPINS; i++) r[i] = v[NPINS-1-i];
    return r;
  endfunction

  localparam logic [NPINS-1:0] DIR_LOCK = flip(IN_ONLY_PINS);

  logic [NPINS-1:0] dir_q, msk_q, sns_lo_q, sns_hi_q;
  logic [NPINS-1:0] evt, set_pin, clr_vec, rd_mux;
  logic [NPINS-1:0] rdata_q;
  logic             rd_valid_q;
  sense_mode_e      mode [NPINS];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= '0;
      msk_q    <= '0;
      sns_lo_q <= '0;
      sns_hi_q <= '0;
    end else if (wr_en) begin
      unique case (addr)
        OFS_DIR:    dir_q    <= wdata & ~DIR_LOCK;
        OFS_MSK:    msk_q    <= wdata;
        OFS_SNS_LO: sns_lo_q <= wdata;
        OFS_SNS_HI: sns_hi_q <= wdata;
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr_en && addr == OFS_EVT) ? wdata : '0;

  gpio_sense_field_map #(.NPINS(NPINS)) i_map (
    .sns_lo_i (sns_lo_q),
    .sns_hi_i (sns_hi_q),
    .mode_o   (mode)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_det
    gpio_pin_event #(.LEVEL(LEVEL_PINS[p])) i_det (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_in[p]),
      .mode_i (mode[p]),
      .set_o  (set_pin[p])
    );
  end

  gpio_event_bank #(.NPINS(NPINS)) i_bank (
    .clk       (clk),
    .rst       (rst),
    .set_vec_i (flip(set_pin)),
    .clr_vec_i (clr_vec),
    .msk_i     (msk_q),
    .evt_o     (evt),
    .irq_o     (irq)
  );

  // Read port
  always_comb begin
    unique case (addr)
      OFS_DIR:    rd_mux = dir_q;
      OFS_EVT:    rd_mux = evt;
      OFS_MSK:    rd_mux = msk_q;
      OFS_SNS_LO: rd_mux = sns_lo_q;
      OFS_SNS_HI: rd_mux = sns_hi_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rd_valid_q;
  assign pin_dir  = flip(dir_q);

  assert_rd_valid_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_dir_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DIR) |=> ((pin_dir & IN_ONLY_PINS) == '0));
endmodule

// File: tb/test_gpio_sense_unit.sv
module test_gpio_sense_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rd_valid, irq;
  logic [31:0] rdata, pin_dir;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_sense_unit i_gpio_sense_unit (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_valid(rd_valid), .rdata(rdata),
    .pin_dir(pin_dir), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int p, input logic v);
    pin_in[p] = v;
    idle(1);
  endtask

  task automatic clear_all();
    bus_wr(5'h0C, 32'hFFFF_FFFF);
  endtask

  // Monitor: pops expected read values in order.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected rd_valid", rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata === e, t, rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(irq === 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
    bus_rd(5'h00, 32'h0, "R1 dir reset");
    bus_rd(5'h0C, 32'h0, "R1 evt reset");
    bus_rd(5'h10, 32'h0, "R1 msk reset");
    bus_rd(5'h14, 32'h0, "R1 sense lo reset");
    bus_rd(5'h18, 32'h0, "R1 sense hi reset");

    // R5 both edges on pin 5 (reset mode)
    set_pin(5, 1'b1);
    bus_rd(5'h0C, 32'h0400_0000, "R5 pin5 rise");
    bus_wr(5'h0C, 32'h0);
    bus_rd(5'h0C, 32'h0400_0000, "R8 zero write keeps bit");
    bus_wr(5'h0C, 32'h0400_0000);
    bus_rd(5'h0C, 32'h0, "R8 one write clears");
    set_pin(5, 1'b0);
    bus_rd(5'h0C, 32'h0400_0000, "R5 pin5 fall");
    clear_all();

    // R2/R3 pin 0 rising via low register bits 31:30
    bus_wr(5'h14, 32'h4000_0000);
    bus_rd(5'h14, 32'h4000_0000, "R2 sense lo readback");
    set_pin(0, 1'b1);
    bus_rd(5'h0C, 32'h8000_0000, "R3 pin0 rise sets bit31");
    clear_all();
    set_pin(0, 1'b0);
    bus_rd(5'h0C, 32'h0, "R3 pin0 fall ignored");

    // R4 pin 17 falling (bits 29:28 of high reg), R6 pin 20 reserved (bits 23:22)
    bus_wr(5'h18, 32'h20C0_0000);
    bus_rd(5'h18, 32'h20C0_0000, "R2 sense hi readback");
    set_pin(17, 1'b1);
    bus_rd(5'h0C, 32'h0, "R4 pin17 rise ignored");
    set_pin(17, 1'b0);
    bus_rd(5'h0C, 32'h0000_4000, "R4 pin17 fall sets bit14");
    clear_all();
    set_pin(20, 1'b1);
    set_pin(20, 1'b0);
    bus_rd(5'h0C, 32'h0, "R6 reserved pin20 quiet");

    // R9 irq: mask pin 5 only
    bus_wr(5'h10, 32'h0400_0000);
    set_pin(6, 1'b1);
    idle(2);
    chk(irq === 1'b0, "R9 unmasked event no irq", {31'b0, irq}, 32'h0);
    pin_in[5] = 1'b1;
    idle(1);
    chk(irq === 1'b0, "R9 irq lags event", {31'b0, irq}, 32'h0);
    idle(1);
    chk(irq === 1'b1, "R9 irq raised", {31'b0, irq}, 32'h1);
    bus_wr(5'h0C, 32'h0400_0000);
    idle(1);
    chk(irq === 1'b0, "R9 irq drops after clear", {31'b0, irq}, 32'h0);
    clear_all();

    // R7 level pins: pin 8 high-level (bits 15:14), pin 9 low-level (bits 13:12)
    bus_wr(5'h14, 32'h4000_6000);
    idle(1);
    bus_rd(5'h0C, 32'h0040_0000, "R7 pin9 low level sets bit22");
    pin_in[8] = 1'b1;
    idle(2);
    bus_wr(5'h0C, 32'h0080_0000);
    bus_rd(5'h0C, 32'h0040_0000, "R7 bit23 cleared for one cycle");
    bus_rd(5'h0C, 32'h00C0_0000, "R7 bit23 set again while high");
    pin_in[8] = 1'b0; pin_in[9] = 1'b1;
    idle(1);
    clear_all();
    idle(1);
    bus_rd(5'h0C, 32'h0, "R7 inactive levels quiet");

    // R8 clear wins over same-cycle event (pin 5 falls, mode both)
    pin_in[5] = 1'b0;
    bus_wr(5'h0C, 32'h0400_0000);
    idle(1);
    bus_rd(5'h0C, 32'h0, "R8 clear beats new event");

    // R10 input-only direction bits
    bus_wr(5'h00, 32'hFFFF_FFFF);
    chk(pin_dir === 32'h0FFF_FFFF, "R10 pin_dir port", pin_dir, 32'h0FFF_FFFF);
    bus_rd(5'h00, 32'hFFFF_FFF0, "R10 dir readback");
    bus_wr(5'h00, 32'h0000_000F);
    bus_rd(5'h00, 32'h0, "R10 locked bits only");

    // R11 unmapped offset
    bus_rd(5'h04, 32'h0, "R11 unmapped reads zero");
    idle(3);
    chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule